// File: doc/BRIEF.md
# Dual-Channel Ancillary Word Buffer with Coded Status

This block holds the ancillary data words pulled out of a video stream until software or a downstream engine collects them. There are two independent queues, one for luma and one for chroma. Each queue is written on the pixel clock and read on a separate user read clock. The two clocks need no fixed relation. The block passes words through unchanged and does not inspect them for errors.

Each queue's state is reduced to a 3-bit code. The code can report empty, below half, at or above half, full, a latched overrun, or a latched underrun. One select input picks which queue's code is shown. The code is published twice: once registered on the pixel clock and once registered on the read clock.

When a write arrives at a full queue, that queue enters overrun. It then drops every further write until the overrun is cleared. A read at an empty queue is an underrun. It leaves the queue untouched, and the read port keeps showing the last word that was delivered.

Top module: `anc_dual_fifo`

## Requirements
- R1: After reset, both status outputs show 001 and both read data outputs are 0.
- R2: When no error is latched, a queue reports the number of words it holds. Zero words gives 001. At least one word but fewer than half the depth gives 010. Half the depth or more, but not all of it, gives 011. Exactly the depth gives 110.
- R3: A write request at a full queue latches overrun, and the code becomes 111. That write, and every later write to the same queue, is discarded while overrun stays latched. This holds even after reads have freed space.
- R4: A read request at an empty queue latches underrun, and the code becomes 000. The read pointer does not move, and the read data output keeps its last value.
- R5: Overrun stays latched until `ovr_clr` is pulsed on the pixel clock. Underrun stays latched until `udr_clr` is pulsed on the read clock. In the code, overrun takes priority over underrun, and underrun takes priority over the level codes.
- R6: With `stat_sel` high, both status outputs describe the luma queue. With `stat_sel` low, they describe the chroma queue.
- R7: A change caused by a write, including an overrun, reaches `rd_status` three read clock edges after the write edge. A change caused by a read, including an underrun, reaches `wr_status` three pixel clock edges after the read edge. In its own clock domain, each change appears one edge after the event.
- R8: Each queue returns its words unaltered and in the order they were written. Traffic on one queue has no effect on the other.
- R9: A read data output changes only on the edge of an accepted read. On that edge it presents the oldest word still held.
- R10: Codes 100 and 101 never appear on either status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Pixel clock (write side) |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| y_wr_en | input | 1 | Luma write request |
| y_wr_data | input | DATA_W | Luma word to store |
| c_wr_en | input | 1 | Chroma write request |
| c_wr_data | input | DATA_W | Chroma word to store |
| ovr_clr | input | 1 | Clears latched overrun on both queues (write side) |
| rd_clk | input | 1 | User read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| y_rd_en | input | 1 | Luma read request |
| y_rd_data | output | DATA_W | Last luma word delivered |
| c_rd_en | input | 1 | Chroma read request |
| c_rd_data | output | DATA_W | Last chroma word delivered |
| udr_clr | input | 1 | Clears latched underrun on both queues (read side) |
| stat_sel | input | 1 | Status view: 1 = luma, 0 = chroma |
| wr_status | output | 3 | Selected queue code, pixel clock domain |
| rd_status | output | 3 | Selected queue code, read clock domain |

## Verification
The bench builds the block with ADDR_W = 4, which gives 16-word queues. With that depth, the half-depth boundary, the full state, the overrun and the writes dropped after it can each be reached in a few dozen cycles. Both clock ports are driven from one 250 MHz wire. This makes the three-edge cross-domain latency an exact edge count, so the bench can check the status one edge before the change and again on the edge where it lands. Underrun is driven at a queue that was just emptied. This shows the held read word, the intact read pointer, and the priority of the sticky code over the level code.

// File: rtl/anc_fifo_pkg.sv
`timescale 1ns/1ps
package anc_fifo_pkg;

  typedef logic [2:0] st_code_t;

  localparam st_code_t ST_UNDERRUN = 3'b000;
  localparam st_code_t ST_EMPTY    = 3'b001;
  localparam st_code_t ST_LOW      = 3'b010;
  localparam st_code_t ST_HIGH     = 3'b011;
  localparam st_code_t ST_FULL     = 3'b110;
  localparam st_code_t ST_OVERRUN  = 3'b111;

  // Priority: overrun, underrun, then fill level.
  function automatic st_code_t st_encode(input logic ovr, input logic udr,
                                         input logic full, input logic empty,
                                         input logic upper);
    st_code_t c;
    if (ovr)        c = ST_OVERRUN;
    else if (udr)   c = ST_UNDERRUN;
    else if (full)  c = ST_FULL;
    else if (empty) c = ST_EMPTY;
    else if (upper) c = ST_HIGH;
    else            c = ST_LOW;
    return c;
  endfunction

endpackage

// File: rtl/anc_ptr_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray pointer or a level flag.
module anc_ptr_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/anc_level_code.sv
`timescale 1ns/1ps
// Turns a pointer pair and the sticky error flags into a status code.
module anc_level_code
  import anc_fifo_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [PTR_W-1:0] wr_bin,
  input  logic [PTR_W-1:0] rd_bin,
  input  logic             ovr,
  input  logic             udr,
  output st_code_t         code
);
  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_LVL = PTR_W'(DEPTH / 2);

  logic [PTR_W-1:0] level;
  logic             full;
  logic             empty;
  logic             upper;

  always_comb begin
    level = wr_bin - rd_bin;
    full  = (level == FULL_LVL);
    empty = (level == '0);
    upper = (level >= HALF_LVL);
    code  = st_encode(ovr, udr, full, empty, upper);
  end
endmodule

// File: rtl/anc_chan_fifo.sv
`timescale 1ns/1ps
// One asynchronous queue: dual-clock storage, Gray pointers, sticky errors.
module anc_chan_fifo
  import anc_fifo_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 10,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ovr_clr,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic              udr_clr,
  output logic [DATA_W-1:0] rd_data,
  output st_code_t          wr_code,
  output st_code_t          rd_code
);
  localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- write side ----------------
  logic [PTR_W-1:0] wbin_q, wgray_q, rgray_w, rbin_w;
  logic             ovr_q, udr_w, full_w, accept_w;

  assign rbin_w   = gray2bin(rgray_w);
  assign full_w   = ((wbin_q - rbin_w) == FULL_LVL);
  assign accept_w = wr_en && !full_w && !ovr_q;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (accept_w) begin
        wbin_q  <= wbin_q + 1'b1;
        wgray_q <= bin2gray(wbin_q + 1'b1);
      end
      ovr_q <= (ovr_q && !ovr_clr) || (wr_en && full_w);
    end
  end

  always_ff @(posedge wr_clk) begin
    if (accept_w) mem[wbin_q[ADDR_W-1:0]] <= wr_data;
  end

  // ---------------- read side ----------------
  logic [PTR_W-1:0]  rbin_q, rgray_q, wgray_r, wbin_r;
  logic              udr_q, ovr_r, empty_r, accept_r;
  logic [DATA_W-1:0] rd_q;

  assign wbin_r   = gray2bin(wgray_r);
  assign empty_r  = (wbin_r == rbin_q);
  assign accept_r = rd_en && !empty_r;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      udr_q   <= 1'b0;
    end else begin
      if (accept_r) begin
        rbin_q  <= rbin_q + 1'b1;
        rgray_q <= bin2gray(rbin_q + 1'b1);
      end
      udr_q <= (udr_q && !udr_clr) || (rd_en && empty_r);
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst)        rd_q <= '0;
    else if (accept_r) rd_q <= mem[rbin_q[ADDR_W-1:0]];
  end

  assign rd_data = rd_q;

  // ---------------- crossings ----------------
  anc_ptr_sync #(.W(PTR_W)) u_wptr_to_rd (
    .clk(rd_clk), .rst(rd_rst), .din(wgray_q), .dout(wgray_r));
  anc_ptr_sync #(.W(PTR_W)) u_rptr_to_wr (
    .clk(wr_clk), .rst(wr_rst), .din(rgray_q), .dout(rgray_w));
  anc_ptr_sync #(.W(1)) u_ovr_to_rd (
    .clk(rd_clk), .rst(rd_rst), .din(ovr_q), .dout(ovr_r));
  anc_ptr_sync #(.W(1)) u_udr_to_wr (
    .clk(wr_clk), .rst(wr_rst), .din(udr_q), .dout(udr_w));

  // ---------------- per-domain views ----------------
  anc_level_code #(.ADDR_W(ADDR_W)) u_wr_view (
    .wr_bin(wbin_q), .rd_bin(rbin_w), .ovr(ovr_q), .udr(udr_w), .code(wr_code));
  anc_level_code #(.ADDR_W(ADDR_W)) u_rd_view (
    .wr_bin(wbin_r), .rd_bin(rbin_q), .ovr(ovr_r), .udr(udr_q), .code(rd_code));
endmodule

// File: rtl/anc_dual_fifo.sv
`timescale 1ns/1ps
// Luma and chroma ancillary queues with a selectable status code per domain.
module anc_dual_fifo
  import anc_fifo_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 10,
  localparam int N_CH  = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              y_wr_en,
  input  logic [DATA_W-1:0] y_wr_data,
  input  logic              c_wr_en,
  input  logic [DATA_W-1:0] c_wr_data,
  input  logic              ovr_clr,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              y_rd_en,
  output logic [DATA_W-1:0] y_rd_data,
  input  logic              c_rd_en,
  output logic [DATA_W-1:0] c_rd_data,
  input  logic              udr_clr,
  input  logic              stat_sel,
  output logic [2:0]        wr_status,
  output logic [2:0]        rd_status
);
  // Index 1 is luma, index 0 is chroma, so stat_sel indexes directly.
  logic              ch_wr_en   [N_CH];
  logic [DATA_W-1:0] ch_wr_data [N_CH];
  logic              ch_rd_en   [N_CH];
  logic [DATA_W-1:0] ch_rd_data [N_CH];
  st_code_t          ch_wr_code [N_CH];
  st_code_t          ch_rd_code [N_CH];

  assign ch_wr_en[0]   = c_wr_en;
  assign ch_wr_en[1]   = y_wr_en;
  assign ch_wr_data[0] = c_wr_data;
  assign ch_wr_data[1] = y_wr_data;
  assign ch_rd_en[0]   = c_rd_en;
  assign ch_rd_en[1]   = y_rd_en;
  assign c_rd_data     = ch_rd_data[0];
  assign y_rd_data     = ch_rd_data[1];

  for (genvar g = 0; g < N_CH; g++) begin : gen_ch
    anc_chan_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ch (
      .wr_clk  (wr_clk),
      .wr_rst  (wr_rst),
      .wr_en   (ch_wr_en[g]),
      .wr_data (ch_wr_data[g]),
      .ovr_clr (ovr_clr),
      .rd_clk  (rd_clk),
      .rd_rst  (rd_rst),
      .rd_en   (ch_rd_en[g]),
      .udr_clr (udr_clr),
      .rd_data (ch_rd_data[g]),
      .wr_code (ch_wr_code[g]),
      .rd_code (ch_rd_code[g])
    );
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) wr_status <= ST_EMPTY;
    else        wr_status <= ch_wr_code[stat_sel];
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) rd_status <= ST_EMPTY;
    else        rd_status <= ch_rd_code[stat_sel];
  end
endmodule

// File: rtl/anc_dual_fifo_chk.sv
`timescale 1ns/1ps
module anc_dual_fifo_chk #(
  parameter int DATA_W = 10
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              stat_sel,
  input logic              ovr_clr,
  input logic              udr_clr,
  input logic              y_rd_en,
  input logic              c_rd_en,
  input logic [DATA_W-1:0] y_rd_data,
  input logic [DATA_W-1:0] c_rd_data,
  input logic [2:0]        wr_status,
  input logic [2:0]        rd_status
);
  AST_WR_CODE_LEGAL: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_status != 3'b100) && (wr_status != 3'b101)); // R10

  AST_RD_CODE_LEGAL: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_status != 3'b100) && (rd_status != 3'b101)); // R10

  AST_OVR_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
    (wr_status == 3'b111 && !$past(ovr_clr) && stat_sel == $past(stat_sel))
    |=> (wr_status == 3'b111)); // R5

  AST_UDR_STICKY: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_status == 3'b000 && !$past(udr_clr) && stat_sel == $past(stat_sel))
    |=> (rd_status == 3'b000)); // R5

  AST_Y_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !y_rd_en |=> $stable(y_rd_data)); // R9

  AST_C_DATA_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !c_rd_en |=> $stable(c_rd_data)); // R9
endmodule

bind anc_dual_fifo anc_dual_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .wr_clk    (wr_clk),
  .wr_rst    (wr_rst),
  .rd_clk    (rd_clk),
  .rd_rst    (rd_rst),
  .stat_sel  (stat_sel),
  .ovr_clr   (ovr_clr),
  .udr_clr   (udr_clr),
  .y_rd_en   (y_rd_en),
  .c_rd_en   (c_rd_en),
  .y_rd_data (y_rd_data),
  .c_rd_data (c_rd_data),
  .wr_status (wr_status),
  .rd_status (rd_status)
);

// File: tb/anc_dual_fifo_bench.sv
`timescale 1ns/1ps
module anc_dual_fifo_bench;
  localparam int DW = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          y_wr_en = 1'b0, c_wr_en = 1'b0;
  logic [DW-1:0] y_wr_data = '0, c_wr_data = '0;
  logic          y_rd_en = 1'b0, c_rd_en = 1'b0;
  logic          ovr_clr = 1'b0, udr_clr = 1'b0, stat_sel = 1'b1;
  logic [DW-1:0] y_rd_data, c_rd_data;
  logic [2:0]    wr_status, rd_status;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  anc_dual_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_anc_dual_fifo (
    .wr_clk(clk), .wr_rst(rst), .y_wr_en(y_wr_en), .y_wr_data(y_wr_data),
    .c_wr_en(c_wr_en), .c_wr_data(c_wr_data), .ovr_clr(ovr_clr),
    .rd_clk(clk), .rd_rst(rst), .y_rd_en(y_rd_en), .y_rd_data(y_rd_data),
    .c_rd_en(c_rd_en), .c_rd_data(c_rd_data), .udr_clr(udr_clr),
    .stat_sel(stat_sel), .wr_status(wr_status), .rd_status(rd_status));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr_y(input logic [DW-1:0] d);
    y_wr_en = 1'b1; y_wr_data = d;
    @(negedge clk);
    y_wr_en = 1'b0;
  endtask

  task automatic wr_c(input logic [DW-1:0] d);
    c_wr_en = 1'b1; c_wr_data = d;
    @(negedge clk);
    c_wr_en = 1'b0;
  endtask

  task automatic rd_y();
    y_rd_en = 1'b1;
    @(negedge clk);
    y_rd_en = 1'b0;
  endtask

  task automatic rd_c();
    c_rd_en = 1'b1;
    @(negedge clk);
    c_rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 wr_status", wr_status, 3'b001);
    chk("R1 rd_status", rd_status, 3'b001);
    chk("R1 y_rd_data", y_rd_data, 0);
    chk("R1 c_rd_data", c_rd_data, 0);
  endtask

  task automatic t_latency();
    stat_sel = 1'b1;
    cyc(1);
    wr_y(10'h101);
    cyc(1);
    chk("R7 wr own domain", wr_status, 3'b010);
    chk("R7 rd edge+1", rd_status, 3'b001);
    cyc(1);
    chk("R7 rd edge+2", rd_status, 3'b001);
    cyc(1);
    chk("R7 rd edge+3", rd_status, 3'b010);
    rd_y();
    chk("R8 first word", y_rd_data, 10'h101);
    cyc(1);
    chk("R7 rd own domain", rd_status, 3'b001);
    cyc(1);
    chk("R7 wr edge+2", wr_status, 3'b010);
    cyc(1);
    chk("R7 wr edge+3", wr_status, 3'b001);
  endtask

  task automatic t_select();
    stat_sel = 1'b0;
    wr_c(10'h0C1);
    wr_c(10'h0C2);
    cyc(4);
    chk("R6 chroma wr", wr_status, 3'b010);
    chk("R6 chroma rd", rd_status, 3'b010);
    stat_sel = 1'b1;
    cyc(1);
    chk("R6 luma wr", wr_status, 3'b001);
    chk("R6 luma rd", rd_status, 3'b001);
    stat_sel = 1'b0;
    cyc(1);
    chk("R6 back chroma", rd_status, 3'b010);
    rd_c();
    chk("R8 chroma word 0", c_rd_data, 10'h0C1);
    chk("R8 luma untouched", y_rd_data, 10'h101);
    rd_c();
    chk("R8 chroma word 1", c_rd_data, 10'h0C2);
    cyc(4);
    chk("R2 chroma empty", rd_status, 3'b001);
    stat_sel = 1'b1;
    cyc(1);
  endtask

  task automatic t_fill_overrun();
    stat_sel = 1'b1;
    for (int i = 0; i < 7; i++) wr_y(DW'(10'h200 + i));
    cyc(4);
    chk("R2 below half wr", wr_status, 3'b010);
    chk("R2 below half rd", rd_status, 3'b010);
    wr_y(10'h207);
    cyc(4);
    chk("R2 at half wr", wr_status, 3'b011);
    chk("R2 at half rd", rd_status, 3'b011);
    for (int i = 8; i < 16; i++) wr_y(DW'(10'h200 + i));
    cyc(4);
    chk("R2 full wr", wr_status, 3'b110);
    chk("R2 full rd", rd_status, 3'b110);
    wr_y(10'h3FF);
    cyc(1);
    chk("R3 overrun wr", wr_status, 3'b111);
    chk("R7 overrun rd not yet", rd_status, 3'b110);
    cyc(2);
    chk("R7 overrun rd edge+3", rd_status, 3'b111);
    rd_y();
    chk("R8 oldest after full", y_rd_data, 10'h200);
    cyc(4);
    wr_y(10'h155);
    cyc(4);
    chk("R3 still overrun wr", wr_status, 3'b111);
    chk("R3 still overrun rd", rd_status, 3'b111);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    cyc(1);
    chk("R5 overrun cleared wr", wr_status, 3'b011);
    cyc(3);
    chk("R5 overrun cleared rd", rd_status, 3'b011);
    for (int i = 1; i < 16; i++) begin
      rd_y();
      chk("R3 order kept, drops absent", y_rd_data, 10'h200 + i);
    end
    cyc(4);
    chk("R3 no dropped word stored wr", wr_status, 3'b001);
    chk("R3 no dropped word stored rd", rd_status, 3'b001);
  endtask

  task automatic t_underrun();
    stat_sel = 1'b1;
    rd_y();
    chk("R4 data held on underrun", y_rd_data, 10'h20F);
    cyc(1);
    chk("R4 underrun rd", rd_status, 3'b000);
    chk("R7 underrun wr not yet", wr_status, 3'b001);
    cyc(2);
    chk("R7 underrun wr edge+3", wr_status, 3'b000);
    wr_y(10'h0AA);
    cyc(4);
    chk("R5 underrun sticky rd", rd_status, 3'b000);
    chk("R5 underrun sticky wr", wr_status, 3'b000);
    chk("R9 data unchanged by write", y_rd_data, 10'h20F);
    udr_clr = 1'b1;
    @(negedge clk);
    udr_clr = 1'b0;
    cyc(1);
    chk("R5 underrun cleared rd", rd_status, 3'b010);
    cyc(3);
    chk("R5 underrun cleared wr", wr_status, 3'b010);
    rd_y();
    chk("R4 pointer unmoved", y_rd_data, 10'h0AA);
    cyc(4);
    chk("R2 empty again", rd_status, 3'b001);
    chk("R10 wr code legal", int'(wr_status == 3'b100 || wr_status == 3'b101), 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_latency();
    t_select();
    t_fill_overrun();
    t_underrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule